// File: doc/BRIEF.md
# Page Table Entry Walker

This block turns a virtual address into a physical address by reading one 32-bit entry from a flat, single-level page table in memory. A request carries the virtual address, whether the access is a write, and whether the requester runs in user mode. The walker forms the entry address from a table base register, reads the entry over a request/response memory port, and checks it. It then answers with the translated address or a fault code. When an allowed access leaves the accessed flag or the dirty flag clear, the walker writes the updated entry back to memory before it answers.

Every request costs one memory read, and sometimes one memory write, before the data access can go ahead. Any caching of translations belongs to a block in front of this one. The base register is loaded through a configuration strobe.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: For each accepted request the walker issues exactly one memory read. Its address is base + 4 × VPN, where the VPN is the virtual address shifted right by OFS_W.
- R3: The entry is decoded as follows: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 5 accessed, bit 6 dirty, and bits 31..12 the frame number. On success the response gives fault code 00 and the address {frame, low OFS_W bits of the virtual address}. For example, with OFS_W=4, virtual address 21 in page 1 mapped to frame 7 gives 117.
- R4: If bit 0 of the entry is 0, the fault code is 01 and the address is 0, whatever the other bits say. No memory write follows.
- R5: If the entry is present, the response gives fault code 10, address 0 and no memory write in either of these cases: a write to an entry whose bit 1 is 0, or a user-mode access to an entry whose bit 2 is 0.
- R6: After a successful access, the walker issues one memory write to the entry address if bit 5 is clear, or if the access is a write and bit 6 is clear. The written word is the entry with bit 5 set, and with bit 6 also set on a write; all other bits are unchanged. In every other case no write is issued.
- R7: `req_ready` is high only while the walker is idle. Once `rsp_valid` rises, it stays high with `rsp_pa` and `rsp_fault` unchanged until `rsp_ready` is seen.
- R8: A load of the base register while a walk is in progress does not change that walk's entry address. It applies from the next request onward.
- R9: A supervisor-mode read or write succeeds on a present entry whose bit 2 is 0, as long as bit 1 allows the access. A read succeeds on an entry whose bit 1 is 0.
- R10: A fault code of 11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_we | input | 1 | Load strobe for the table base register |
| cfg_base | input | MA_W | New table base byte address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted on valid |
| req_va | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Result consumed |
| rsp_pa | output | 20+OFS_W | Physical address, 0 on fault |
| rsp_fault | output | 2 | 00 ok, 01 not present, 10 protection |
| mem_req_valid | output | 1 | Memory access valid |
| mem_req_ready | input | 1 | Memory accepts access |
| mem_req_write | output | 1 | 1 = entry write-back, 0 = entry read |
| mem_req_addr | output | MA_W | Entry byte address |
| mem_req_wdata | output | 32 | Updated entry for write-back |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Entry read from memory |

## Verification
The bench builds the walker with VA_W=6, OFS_W=4 and MA_W=10. That gives four virtual pages and a 256-word table memory held in the bench, small enough to make the 21 → 117 mapping a directed case. Random base values move the table around the whole memory. Random entries hit every combination of the present, writable, user, accessed and dirty flags many times, while random memory and response stalls exercise the handshake holds.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int OFS_W = 12,
  parameter int MA_W  = 32,
  localparam int PFN_W = 20,
  localparam int PA_W  = PFN_W + OFS_W,
  localparam int VPN_W = VA_W - OFS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_base_we,
  input  logic [MA_W-1:0] cfg_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_va,
  input  logic            req_write,
  input  logic            req_user,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PA_W-1:0] rsp_pa,
  output logic [1:0]      rsp_fault,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [MA_W-1:0] mem_req_addr,
  output logic [31:0]     mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [31:0]     mem_rsp_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WAIT, S_CHECK, S_UPDATE, S_RESP} state_t;

  state_t           state;
  logic [MA_W-1:0]  base_q, ent_addr_q;
  logic [OFS_W-1:0] ofs_q;
  logic             wr_q, user_q;
  logic [31:0]      ent_q;
  logic [PA_W-1:0]  pa_q;
  logic [1:0]       fault_q;

  logic [VPN_W-1:0] vpn;
  logic [1:0]       fault_c;
  logic [31:0]      ent_upd;

  assign vpn     = req_va[VA_W-1:OFS_W];
  assign fault_c = !ent_q[0] ? 2'b01 :
                   ((wr_q && !ent_q[1]) || (user_q && !ent_q[2])) ? 2'b10 : 2'b00;
  assign ent_upd = ent_q | 32'h20 | (wr_q ? 32'h40 : 32'h0);

  assign req_ready     = (state == S_IDLE);
  assign rsp_valid     = (state == S_RESP);
  assign rsp_pa        = pa_q;
  assign rsp_fault     = fault_q;
  assign mem_req_valid = (state == S_FETCH) || (state == S_UPDATE);
  assign mem_req_write = (state == S_UPDATE);
  assign mem_req_addr  = ent_addr_q;
  assign mem_req_wdata = ent_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      base_q     <= '0;
      ent_addr_q <= '0;
      ofs_q      <= '0;
      wr_q       <= 1'b0;
      user_q     <= 1'b0;
      ent_q      <= '0;
      pa_q       <= '0;
      fault_q    <= 2'b00;
    end else begin
      if (cfg_base_we) base_q <= cfg_base;
      case (state)
        S_IDLE: if (req_valid) begin
          ent_addr_q <= base_q + (MA_W'(vpn) << 2);
          ofs_q      <= req_va[OFS_W-1:0];
          wr_q       <= req_write;
          user_q     <= req_user;
          state      <= S_FETCH;
        end
        S_FETCH: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          ent_q <= mem_rsp_rdata;
          state <= S_CHECK;
        end
        S_CHECK: begin
          fault_q <= fault_c;
          pa_q    <= (fault_c == 2'b00) ? {ent_q[31:12], ofs_q} : '0;
          if (fault_c == 2'b00 && ent_upd != ent_q) begin
            ent_q <= ent_upd;
            state <= S_UPDATE;
          end else begin
            state <= S_RESP;
          end
        end
        S_UPDATE: if (mem_req_ready) state <= S_RESP;
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault));

  a_r7_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_req_valid);

  a_r2_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  a_r10_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'b11);

  a_r4_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'b00 |-> rsp_pa == '0);

  a_r6_wb_flags: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[0] && mem_req_wdata[5]);

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 6, OFS_W = 4, MA_W = 10, PA_W = 20 + OFS_W;

  logic clk = 0, rst_n = 0;
  logic cfg_base_we = 0;
  logic [MA_W-1:0] cfg_base = '0;
  logic req_valid = 0, req_write = 0, req_user = 0, rsp_ready = 0;
  logic [VA_W-1:0] req_va = '0;
  logic req_ready, rsp_valid, mem_req_valid, mem_req_write;
  logic [PA_W-1:0] rsp_pa;
  logic [1:0] rsp_fault;
  logic [MA_W-1:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic [31:0] mem_rsp_rdata = '0;

  int total = 0, bad = 0;
  logic [31:0] mem [0:255];
  int nrd = 0, nwr = 0;
  logic [MA_W-1:0] last_rd;
  logic pend = 0;
  logic [MA_W-1:0] pend_addr;
  int dly = 0;
  logic [MA_W-1:0] base_cur = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker #(.VA_W(VA_W), .OFS_W(OFS_W), .MA_W(MA_W)) i_pt_walker (
    .clk(clk), .rst_n(rst_n), .cfg_base_we(cfg_base_we), .cfg_base(cfg_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata));

  always @(posedge clk) begin
    mem_req_ready <= ($urandom % 3) != 0;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr[9:2]] <= mem_req_wdata;
        nwr <= nwr + 1;
      end else begin
        pend <= 1'b1; pend_addr <= mem_req_addr; dly <= $urandom % 3;
        nrd <= nrd + 1; last_rd <= mem_req_addr;
      end
    end
    if (pend) begin
      if (dly == 0) begin
        mem_rsp_valid <= 1'b1; mem_rsp_rdata <= mem[pend_addr[9:2]]; pend <= 1'b0;
      end else dly <= dly - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_fault(input logic [31:0] e, input logic wr, input logic usr);
    if (!e[0]) return 2'b01;
    if ((wr && !e[1]) || (usr && !e[2])) return 2'b10;
    return 2'b00;
  endfunction

  task automatic run(input logic [VA_W-1:0] va, input logic wr, input logic usr,
                     input string tag, input bit chg_base, input logic [MA_W-1:0] nb);
    logic [MA_W-1:0] ea;
    logic [31:0] e, eu;
    logic [1:0] ef;
    logic [PA_W-1:0] epa;
    int rd0, wr0, ewr, hold;
    ea  = base_cur + (MA_W'(va[VA_W-1:OFS_W]) << 2);
    e   = mem[ea[9:2]];
    ef  = exp_fault(e, wr, usr);
    epa = (ef == 2'b00) ? {e[31:12], va[OFS_W-1:0]} : '0;
    eu  = (ef == 2'b00) ? (e | 32'h20 | (wr ? 32'h40 : 32'h0)) : e;
    ewr = (eu != e) ? 1 : 0;
    rd0 = nrd; wr0 = nwr;
    @(negedge clk);
    req_valid = 1; req_va = va; req_write = wr; req_user = usr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, "R7", "busy ready", 32'(req_ready), 0);
    if (chg_base) begin
      cfg_base_we = 1; cfg_base = nb;
      @(negedge clk);
      cfg_base_we = 0;
      base_cur = nb;
    end
    while (!rsp_valid) @(negedge clk);
    hold = $urandom % 3;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_pa == epa, "R7", "held rsp", 32'(rsp_pa), 32'(epa));
    end
    chk(rsp_fault == ef, tag, "fault", 32'(rsp_fault), 32'(ef));
    chk(rsp_pa == epa, tag, "pa", 32'(rsp_pa), 32'(epa));
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(nrd - rd0 == 1 && last_rd == ea, "R2", "entry read addr", 32'(last_rd), 32'(ea));
    chk(nwr - wr0 == ewr, "R6", "write count", 32'(nwr - wr0), 32'(ewr));
    chk(mem[ea[9:2]] == eu, "R6", "entry after", mem[ea[9:2]], eu);
  endtask

  task automatic set_base(input logic [MA_W-1:0] b);
    @(negedge clk);
    cfg_base_we = 1; cfg_base = b;
    @(negedge clk);
    cfg_base_we = 0;
    base_cur = b;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && mem_req_valid == 0, "R1", "reset outputs",
        {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
    rst_n = 1;

    set_base(10'h040);
    mem[17] = {20'd7, 12'h007};
    run(6'd21, 1'b0, 1'b1, "R3", 0, '0);
    chk(mem[17] == {20'd7, 12'h027}, "R6", "accessed set", mem[17], {20'd7, 12'h027});
    mem[18] = {20'd3, 12'h000};
    run(6'd37, 1'b1, 1'b1, "R4", 0, '0);
    mem[19] = {20'd9, 12'h061};
    run(6'd49, 1'b1, 1'b0, "R5", 0, '0);
    run(6'd50, 1'b0, 1'b1, "R5", 0, '0);
    run(6'd51, 1'b0, 1'b0, "R9", 0, '0);
    mem[16] = {20'd5, 12'h023};
    run(6'd2, 1'b1, 1'b0, "R9", 0, '0);
    run(6'd3, 1'b1, 1'b0, "R6", 0, '0);
    mem[17] = {20'd11, 12'h007};
    mem[33] = {20'd12, 12'h007};
    run(6'd20, 1'b0, 1'b0, "R8", 1, 10'h080);
    run(6'd20, 1'b0, 1'b0, "R8", 0, '0);

    for (int n = 0; n < 400; n++) begin
      if ($urandom % 8 == 0) set_base(MA_W'(($urandom % 252) * 4));
      run(VA_W'($urandom), 1'($urandom), 1'($urandom), "R3", ($urandom % 10) == 0,
          MA_W'(($urandom % 252) * 4));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule